// File: doc/BRIEF.md
# Combo ROM/SRAM bus controller

This block sits on the host side of an external, asynchronous, byte-wide memory device. The device holds a read-only region and a static RAM region. Both regions share one address bus and one data bus, and each has its own active-low select. The host issues one access at a time over a request/acknowledge port. Each access carries an address, a region flag, a read/write flag and, for writes, a data byte. The controller drives the strobes, the address, the outgoing data and the tri-state enable of the data bus. It times every phase as a whole number of clock cycles, derived from parameters.

The host raises `req` with its fields and holds them until `ack` pulses. A read returns its byte on `rdata` in the same cycle as `ack`. After an access, the select of the region just used stays low, so another access to the same region can follow directly. An access to the other region first spends one cycle with both selects high. The RAM region can be narrower than the ROM region. During a RAM access, the address lines above the RAM width are driven to zero.

Top module: `romram_bus_ctrl`

## Requirements
- R1: During and after reset, with no access yet made, both selects, `we_n` and `oe_n` are high, `dq_oe` and `ack` are 0 and `mem_addr` is 0.
- R2: `rom_sel_n` and `ram_sel_n` are never low together. When an access targets the region other than the one whose select is parked low, the controller drives exactly one cycle with both selects high before the new select falls.
- R3: A ROM read (`req_ram`=0, `req_wr`=0) drives all 18 bits of `req_addr` on `mem_addr`. It holds `rom_sel_n` and `oe_n` low, and `we_n` high, for RD_CYC cycles.
- R4: Every RAM access drives `mem_addr` with bits above RAM_AW-1 at 0 and the low RAM_AW bits equal to `req_addr`. A RAM read holds `ram_sel_n` and `oe_n` low for RD_CYC cycles.
- R5: A RAM write (`req_ram`=1, `req_wr`=1) holds `ram_sel_n` and `we_n` low for WP_CYC cycles, with `dq_out` = `req_wdata` and `dq_oe` = 1.
- R6: After `we_n` rises, `dq_oe` and `dq_out` stay unchanged for a further max(1, WC_CYC-WP_CYC) cycles, with the select still low.
- R7: `dq_oe` is 1 only during a write, and `oe_n` is high in every cycle in which `dq_oe` is 1.
- R8: `ack` is high for exactly one cycle, the cycle after the last access phase. For a read, `rdata` in that cycle equals `dq_in` as sampled in the last read cycle.
- R9: Each phase count is the ceiling of its time parameter divided by CLK_PS, with a floor of 1: RD_CYC from T_READ_PS, WP_CYC from T_WPULSE_PS, WC_CYC from T_WCYCLE_PS.
- R10: After an access, the select of its region stays low, with `oe_n` and `we_n` high. A following access to the same region starts at the acceptance edge without a gap cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, held until `ack` |
| req_ram | input | 1 | Region: 0 ROM, 1 RAM |
| req_wr | input | 1 | 1 write (RAM only), 0 read |
| req_addr | input | ROM_AW | Byte address |
| req_wdata | input | DW | Write byte |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Read byte, valid with `ack` |
| mem_addr | output | ROM_AW | Address bus to the device |
| rom_sel_n | output | 1 | ROM region select, active low |
| ram_sel_n | output | 1 | RAM region select, active low |
| we_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| dq_out | output | DW | Data driven toward the device |
| dq_oe | output | 1 | Tri-state enable for `dq_out` |
| dq_in | input | DW | Data bus as seen from the device |

## Verification
ROM reads at the lowest and highest addresses, issued back to back, separate a correct parked select from a spurious gap cycle. They also show that all address bits reach the bus. A RAM write at an address with its top bit set, followed by a read at the same narrowed address, shows that the upper lines are forced to zero and that the write landed in the memory model. Alternating ROM and RAM accesses make the controller insert the single both-high cycle. Back-to-back writes and then reads of neighbouring RAM bytes check the exact lengths of the pulse and the hold phase, and whether `rdata` returns the byte captured in the last read cycle.

// File: rtl/rrb_pkg.sv
`timescale 1ns/1ps
package rrb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_READ,
    ST_WPULSE,
    ST_WHOLD
  } rrb_state_e;

  // whole clock cycles covering a time, never fewer than one
  function automatic int unsigned cycles_for(input int unsigned t_ps,
                                             input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned hold_after(input int unsigned wc,
                                             input int unsigned wp);
    return (wc > wp) ? (wc - wp) : 1;
  endfunction

endpackage

// File: rtl/rrb_phase_cnt.sv
`timescale 1ns/1ps
module rrb_phase_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R9: a count of one expires on the following cycle
  p_cnt_reach_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == CW'(1)) |=> expired);

endmodule

// File: rtl/rrb_addr_map.sv
`timescale 1ns/1ps
module rrb_addr_map #(
  parameter int ROM_AW = 18,
  parameter int RAM_AW = 17
) (
  input  logic [ROM_AW-1:0] host_addr,
  input  logic              to_ram,
  output logic [ROM_AW-1:0] bus_addr
);

  localparam int PAD = ROM_AW - RAM_AW;

  generate
    if (PAD > 0) begin : g_narrow
      assign bus_addr = to_ram ? {{PAD{1'b0}}, host_addr[RAM_AW-1:0]} : host_addr;
    end else begin : g_full
      assign bus_addr = host_addr;
    end
  endgenerate

endmodule

// File: rtl/romram_bus_ctrl.sv
`timescale 1ns/1ps
module romram_bus_ctrl
  import rrb_pkg::*;
#(
  parameter int CLK_PS      = 5000,
  parameter int T_READ_PS   = 70000,
  parameter int T_WPULSE_PS = 60000,
  parameter int T_WCYCLE_PS = 70000,
  parameter int ROM_AW      = 18,
  parameter int RAM_AW      = 17,
  parameter int DW          = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_ram,
  input  logic              req_wr,
  input  logic [ROM_AW-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              ack,
  output logic [DW-1:0]     rdata,
  output logic [ROM_AW-1:0] mem_addr,
  output logic              rom_sel_n,
  output logic              ram_sel_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [DW-1:0]     dq_out,
  output logic              dq_oe,
  input  logic [DW-1:0]     dq_in
);

  localparam int RD_CYC   = cycles_for(T_READ_PS, CLK_PS);
  localparam int WP_CYC   = cycles_for(T_WPULSE_PS, CLK_PS);
  localparam int WC_CYC   = cycles_for(T_WCYCLE_PS, CLK_PS);
  localparam int HOLD_CYC = hold_after(WC_CYC, WP_CYC);
  localparam int MAX_CYC  = (RD_CYC > WP_CYC) ?
                            ((RD_CYC > HOLD_CYC) ? RD_CYC : HOLD_CYC) :
                            ((WP_CYC > HOLD_CYC) ? WP_CYC : HOLD_CYC);
  localparam int CW       = $clog2(MAX_CYC + 1);

  rrb_state_e        state;
  logic              cur_ram, cur_wr;
  logic              park_vld, park_ram;
  logic [ROM_AW-1:0] mapped_addr;

  // named events shared by the datapath and the assertions
  logic          accept, conflict, start, st_ram, st_wr;
  logic          pulse_end, read_done, write_done, expired, cnt_load;
  logic [CW-1:0] cnt_val;

  assign accept     = (state == ST_IDLE) && req;
  assign conflict   = park_vld && (park_ram != req_ram);
  assign start      = (accept && !conflict) || (state == ST_GAP);
  assign st_ram     = (state == ST_GAP) ? cur_ram : req_ram;
  assign st_wr      = (state == ST_GAP) ? cur_wr  : req_wr;
  assign pulse_end  = (state == ST_WPULSE) && expired;
  assign read_done  = (state == ST_READ)   && expired;
  assign write_done = (state == ST_WHOLD)  && expired;
  assign cnt_load   = start || pulse_end;
  assign cnt_val    = pulse_end ? CW'(HOLD_CYC - 1) :
                      (st_wr ? CW'(WP_CYC - 1) : CW'(RD_CYC - 1));

  rrb_phase_cnt #(.CW(CW)) i_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .expired  (expired)
  );

  rrb_addr_map #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) i_map (
    .host_addr (req_addr),
    .to_ram    (req_ram),
    .bus_addr  (mapped_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_ram   <= 1'b0;
      cur_wr    <= 1'b0;
      park_vld  <= 1'b0;
      park_ram  <= 1'b0;
      ack       <= 1'b0;
      rdata     <= '0;
      mem_addr  <= '0;
      rom_sel_n <= 1'b1;
      ram_sel_n <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
    end else begin
      ack <= read_done || write_done;
      if (accept) begin
        mem_addr <= mapped_addr;
        cur_ram  <= req_ram;
        cur_wr   <= req_wr;
        if (req_wr) dq_out <= req_wdata;
      end
      if (accept && conflict) begin
        rom_sel_n <= 1'b1;
        ram_sel_n <= 1'b1;
        park_vld  <= 1'b0;
      end
      if (start) begin
        rom_sel_n <= st_ram;
        ram_sel_n <= !st_ram;
        we_n      <= !st_wr;
        oe_n      <= st_wr;
        dq_oe     <= st_wr;
        park_vld  <= 1'b1;
        park_ram  <= st_ram;
      end
      if (pulse_end)  we_n <= 1'b1;
      if (read_done) begin
        rdata <= dq_in;
        oe_n  <= 1'b1;
      end
      if (write_done) dq_oe <= 1'b0;

      case (state)
        ST_IDLE:   if (accept) state <= conflict ? ST_GAP :
                                        (req_wr ? ST_WPULSE : ST_READ);
        ST_GAP:    state <= cur_wr ? ST_WPULSE : ST_READ;
        ST_READ:   if (expired) state <= ST_IDLE;
        ST_WPULSE: if (expired) state <= ST_WHOLD;
        ST_WHOLD:  if (expired) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R2: the two region selects are exclusive
  p_sel_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_sel_n && !ram_sel_n));

  // R2: a select falls only after a cycle with the other one high
  p_rom_fall_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_sel_n) |-> $past(ram_sel_n));

  p_ram_fall_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_sel_n) |-> $past(rom_sel_n));

  // R7: the controller never drives while the device may drive
  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  // R5: the write strobe only pulses inside a driven RAM access
  p_write_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ram_sel_n && dq_oe && rom_sel_n));

  // R6: data stays driven while the write strobe rises
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (dq_oe && $stable(dq_out)));

  // R8: acknowledge is a single-cycle pulse
  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R4: unused upper lines stay at zero during RAM access
  generate
    if (ROM_AW > RAM_AW) begin : g_hi_chk
      p_ram_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_sel_n |-> (mem_addr[ROM_AW-1:RAM_AW] == '0));
    end
  endgenerate

endmodule

// File: tb/test_romram_bus_ctrl.sv
`timescale 1ns/1ps
module test_romram_bus_ctrl;

  localparam int CLK_PS = 5000;
  localparam int AW     = 18;
  localparam int RAW    = 17;

  // R9: phase lengths worked out here independently
  localparam int RD_N   = (70000 + CLK_PS - 1) / CLK_PS;
  localparam int WP_N   = (60000 + CLK_PS - 1) / CLK_PS;
  localparam int WC_N   = (70000 + CLK_PS - 1) / CLK_PS;
  localparam int HOLD_N = (WC_N - WP_N > 0) ? (WC_N - WP_N) : 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, req_ram = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_wdata = '0;
  logic          ack, rom_sel_n, ram_sel_n, we_n, oe_n, dq_oe;
  logic [7:0]    rdata, dq_out;
  logic [7:0]    dq_in = 8'hEE;
  logic [AW-1:0] mem_addr;

  always #2.5 clk = ~clk;

  romram_bus_ctrl i_romram_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_ram(req_ram), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
    .mem_addr(mem_addr), .rom_sel_n(rom_sel_n), .ram_sel_n(ram_sel_n),
    .we_n(we_n), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  typedef struct {
    logic [5:0]    ctl;   // rom_n ram_n we_n oe_n dq_oe ack
    logic [AW-1:0] addr;
    logic [7:0]    dout;
    bit            chk_dout;
    bit            chk_rd;
    logic [7:0]    rd;
    string         tag;
  } cyc_t;

  cyc_t          plan[$];
  int            checks = 0, failures = 0;
  int            park = 0;          // 0 none, 1 ROM, 2 RAM
  logic [AW-1:0] last_addr = '0;
  logic [7:0]    bus_ram [int];
  logic [7:0]    shadow  [int];
  bit            win = 0;
  int            win_key = 0;
  logic [7:0]    win_data = 0;
  int            cyc_count = 0;

  function automatic logic [7:0] rom_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[17:10] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ram_init(input int k);
    return 8'(k) + 8'(k >> 9);
  endfunction

  function automatic cyc_t mk(input logic [5:0] ctl, input logic [AW-1:0] a,
                              input string tag);
    cyc_t c;
    c.ctl = ctl; c.addr = a; c.dout = 0; c.chk_dout = 0;
    c.chk_rd = 0; c.rd = 0; c.tag = tag;
    return c;
  endfunction

  // compare every cycle, then play the device
  always @(negedge clk) begin
    cyc_t e;
    logic [5:0] act;
    bit bad;
    if (plan.size() > 0) e = plan.pop_front();
    else if (park == 0) e = mk(6'b111100, last_addr, "R1");
    else if (park == 1) e = mk(6'b011100, last_addr, "R10");
    else                e = mk(6'b101100, last_addr, "R10");
    act = {rom_sel_n, ram_sel_n, we_n, oe_n, dq_oe, ack};
    bad = (act !== e.ctl) || (mem_addr !== e.addr) ||
          (e.chk_dout && dq_out !== e.dout) || (e.chk_rd && rdata !== e.rd);
    checks++;
    if (bad) begin
      failures++;
      $display("FAIL %s t=%0t ctl=%b/%b addr=%h/%h dout=%h/%h rdata=%h/%h",
               e.tag, $time, act, e.ctl, mem_addr, e.addr, dq_out, e.dout,
               rdata, e.rd);
    end
    // device write window: committed when it closes
    if (!ram_sel_n && !we_n) begin
      win = 1; win_key = int'(mem_addr[RAW-1:0]); win_data = dq_out;
    end else if (win) begin
      bus_ram[win_key] = win_data; win = 0;
    end
    if (!rom_sel_n && !oe_n) dq_in = rom_byte(mem_addr);
    else if (!ram_sel_n && !oe_n && we_n) begin
      int k;
      k = int'(mem_addr[RAW-1:0]);
      dq_in = bus_ram.exists(k) ? bus_ram[k] : ram_init(k);
    end else dq_in = 8'hEE;
  end

  always @(posedge clk) begin
    cyc_count++;
    if (cyc_count > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // called just after a falling edge; returns just after the ack cycle
  task automatic access(input bit is_ram, input bit is_wr,
                        input logic [AW-1:0] a, input logic [7:0] d);
    logic [AW-1:0] ea;
    int key;
    logic [1:0] sel;
    cyc_t c;
    int want;
    want = is_ram ? 2 : 1;
    key  = int'(a[RAW-1:0]);
    ea   = is_ram ? {{(AW-RAW){1'b0}}, a[RAW-1:0]} : a;
    sel  = is_ram ? 2'b10 : 2'b01;
    req = 1; req_ram = is_ram; req_wr = is_wr; req_addr = a; req_wdata = d;
    if (park != 0 && park != want) plan.push_back(mk(6'b111100, ea, "R2"));
    if (is_wr) begin
      for (int i = 0; i < WP_N; i++) begin
        c = mk({sel, 4'b0110}, ea, is_ram ? "R4 R5 R7 R9" : "R5");
        c.dout = d; c.chk_dout = 1; plan.push_back(c);
      end
      for (int i = 0; i < HOLD_N; i++) begin
        c = mk({sel, 4'b1110}, ea, "R6 R7 R9");
        c.dout = d; c.chk_dout = 1; plan.push_back(c);
      end
      plan.push_back(mk({sel, 4'b1101}, ea, "R8"));
      shadow[key] = d;
    end else begin
      for (int i = 0; i < RD_N; i++)
        plan.push_back(mk({sel, 4'b1000}, ea, is_ram ? "R4 R9" : "R3 R9"));
      c = mk({sel, 4'b1101}, ea, "R8");
      c.chk_rd = 1;
      c.rd = is_ram ? (shadow.exists(key) ? shadow[key] : ram_init(key))
                    : rom_byte(a);
      plan.push_back(c);
    end
    park = want; last_addr = ea;
    do begin @(negedge clk); #1; end while (!ack);
    req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    access(0, 0, 18'h00000, 8'h00);   // R3 lowest
    access(0, 0, 18'h3FFFF, 8'h00);   // R3 R10 highest, no gap
    access(1, 1, 18'h00010, 8'hA5);   // R2 gap, R5 R6
    access(1, 0, 18'h00010, 8'h00);   // R8 readback
    idle(3);
    access(1, 1, 18'h3ABCD, 8'h3C);   // R4 top bit dropped
    access(1, 0, 18'h1ABCD, 8'h00);   // R4 same byte
    access(0, 0, 18'h25A5A, 8'h00);   // R2 back to ROM
    access(1, 0, 18'h00020, 8'h00);   // R2 unwritten byte
    access(1, 1, 18'h00020, 8'h00);   // R10 back-to-back writes
    access(1, 1, 18'h00021, 8'hFF);
    access(1, 0, 18'h00020, 8'h00);
    access(1, 0, 18'h00021, 8'h00);
    idle(2);
    access(0, 0, 18'h12345, 8'h00);   // R3
    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule